// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches up to eight external interrupt pins that arrive asynchronously to the system clock. Each pin first passes through a two-stage synchroniser. A programmable sense mode then decides whether a falling edge, a rising edge, either edge, a low level or a high level counts as a request, and the result is kept in a per-pin pending bit. A pending bit drives that pin's interrupt only when the pin is unmasked and its priority field is nonzero.

Software reaches the block through a single-cycle register port. The port holds a sense register, a priority register, a pending register, a write-only mask-set register, a write-only mask-clear register and a mode register. The qualified requests from all pins are ORed into one combined output. The per-pin outputs are driven only while the mode register selects individual-pin operation.

Top module: `extirq_ctrl`

## Requirements
- R1: After reset, every pin is masked, and the sense, priority, pending and mode registers all read zero. `irq_o` and `irq_any_o` are low.
- R2: Register word addresses are 0 for sense, 1 for priority, 2 for pending, 3 for mask-set, 4 for mask-clear and 5 for mode. Pin n owns the sense field at bit 32-(n+1)*SENSE_W and the 4-bit priority field at bit 32-(n+1)*4, so pin 0 sits at the top. Both registers read back what was written.
- R3: Sense code 0 sets the pending bit on a falling pin edge and code 1 on a rising edge. In an edge mode the opposite transition sets nothing. The pending bit is visible three clock edges after the pin changes and not after two.
- R4: Sense code 4 sets the pending bit on both edges, which needs 4-bit sense fields. Codes 5 to 15 never set a pending bit.
- R5: Code 3 (high level) and code 2 (low level) make the pending bit follow the synchronised active level. A clear written while the level is active leaves the bit set, and the bit drops once the level goes inactive.
- R6: The pending register has one bit per pin, with pin n at bit SRC_W-1-n. Writing 0 to a bit clears that pin's pending bit and writing 1 leaves it unchanged.
- R7: Writing 1 to bit SRC_W-1-n of the mask-set register masks pin n. The same bit of the mask-clear register unmasks it. Zero bits in either write have no effect, and both registers read as zero.
- R8: A pin's request reaches the outputs only while its priority field is nonzero, whatever the mask.
- R9: `irq_any_o` is the OR of all pending, unmasked, nonzero-priority pins. `irq_o[n]` carries pin n's qualified request only while mode bit 23 is set, and is otherwise zero. Only bit 23 of the mode register is stored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pins_i | input | NUM_PINS | Asynchronous external interrupt pins, bit n is pin n |
| reg_addr | input | 3 | Register word address |
| reg_we | input | 1 | Write enable, one write per cycle |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register, combinational |
| irq_o | output | NUM_PINS | Per-pin qualified interrupt, bit n is pin n |
| irq_any_o | output | 1 | OR of all qualified pin requests |

## Verification
Each sense mode gets both pin transitions. A rising-only pin must ignore a fall, a falling-only pin must ignore a rise, the both-edges code must catch each direction, and the unused codes must catch neither. The level modes are driven with the pin held active while software tries to clear, which separates a level that is followed from one that is latched. Clear writes that mix zeros and ones over several pending pins show that only the zero positions are cleared. The gating sequence steps through mask, priority and mode one at a time with a pin already pending, so a fault in any single gate shows up on `irq_o` or `irq_any_o`.

// File: rtl/extirq_pkg.sv
package extirq_pkg;

    localparam int DATA_W   = 32;
    localparam int PRIO_W   = 4;
    localparam int MODE_BIT = 23;

    localparam logic [3:0] SNS_FALL   = 4'd0;
    localparam logic [3:0] SNS_RISE   = 4'd1;
    localparam logic [3:0] SNS_LVL_LO = 4'd2;
    localparam logic [3:0] SNS_LVL_HI = 4'd3;
    localparam logic [3:0] SNS_BOTH   = 4'd4;

    typedef enum logic [2:0] {
        RS_SENSE  = 3'd0,
        RS_PRIO   = 3'd1,
        RS_SOURCE = 3'd2,
        RS_MSET   = 3'd3,
        RS_MCLR   = 3'd4,
        RS_MODE   = 3'd5,
        RS_RSV6   = 3'd6,
        RS_RSV7   = 3'd7
    } reg_sel_e;

    typedef struct packed {
        logic fall;
        logic rise;
        logic lvl_lo;
        logic lvl_hi;
    } detect_sel_t;

    function automatic detect_sel_t decode_sense(input logic [3:0] code);
        detect_sel_t s;
        s.fall   = (code == SNS_FALL)   || (code == SNS_BOTH);
        s.rise   = (code == SNS_RISE)   || (code == SNS_BOTH);
        s.lvl_lo = (code == SNS_LVL_LO);
        s.lvl_hi = (code == SNS_LVL_HI);
        return s;
    endfunction

    function automatic int field_lsb(input int pin, input int width);
        return DATA_W - (pin + 1) * width;
    endfunction

    function automatic int bit_pos(input int pin, input int reg_w);
        return reg_w - 1 - pin;
    endfunction

endpackage

// File: rtl/extirq_sync.sv
module extirq_sync #(
    parameter int NUM_PINS = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    output logic [NUM_PINS-1:0] lvl_o,
    output logic [NUM_PINS-1:0] prev_o
);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
        logic meta_q, lvl_q, prev_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q <= 1'b0;
                lvl_q  <= 1'b0;
                prev_q <= 1'b0;
            end else begin
                meta_q <= pins_i[n];
                lvl_q  <= meta_q;
                prev_q <= lvl_q;
            end
        end

        assign lvl_o[n]  = lvl_q;
        assign prev_o[n] = prev_q;
    end

endmodule

// File: rtl/extirq_pend_cell.sv
module extirq_pend_cell
    import extirq_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  detect_sel_t sel_i,
    input  logic        lvl_i,
    input  logic        prev_i,
    input  logic        clr_i,
    output logic        pend_o
);

    logic pend_q, pend_d;
    logic edge_hit, level_mode, level_active;

    always_comb begin
        edge_hit     = (sel_i.rise &  lvl_i & ~prev_i)
                     | (sel_i.fall & ~lvl_i &  prev_i);
        level_mode   = sel_i.lvl_hi | sel_i.lvl_lo;
        level_active = (sel_i.lvl_hi & lvl_i) | (sel_i.lvl_lo & ~lvl_i);
        if (level_mode) begin
            pend_d = level_active;
        end else begin
            pend_d = (pend_q & ~clr_i) | edge_hit;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) pend_q <= 1'b0;
        else     pend_q <= pend_d;
    end

    assign pend_o = pend_q;

    // R3 / R4: a selected transition always leaves the bit set
    a_r3_edge_sets: assert property (@(posedge clk) disable iff (rst)
        edge_hit |=> pend_q);

    // R5: in a level mode the bit tracks the synchronised active level
    a_r5_level_tracks: assert property (@(posedge clk) disable iff (rst)
        level_mode |=> (pend_q == $past(level_active)));

    // R6: a clear with no concurrent event empties the bit
    a_r6_clear_works: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !level_mode && !edge_hit) |=> !pend_q);

    // R4: with no mode selected the bit never rises
    a_r4_idle_code: assert property (@(posedge clk) disable iff (rst)
        (sel_i == '0 && !pend_q) |=> !pend_q);

endmodule

// File: rtl/extirq_regs.sv
module extirq_regs
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [2:0]            reg_addr,
    input  logic                  reg_we,
    input  logic [DATA_W-1:0]     reg_wdata,
    output logic [DATA_W-1:0]     reg_rdata,
    input  logic [NUM_PINS-1:0]   pend_i,
    output logic [NUM_PINS*4-1:0] sense_code_o,
    output logic [NUM_PINS-1:0]   prio_en_o,
    output logic [NUM_PINS-1:0]   mask_o,
    output logic [NUM_PINS-1:0]   clr_o,
    output logic                  indiv_mode_o
);

    reg_sel_e sel;
    assign sel = reg_sel_e'(reg_addr);

    logic [SENSE_W-1:0] sense_q [NUM_PINS];
    logic [PRIO_W-1:0]  prio_q  [NUM_PINS];
    logic [NUM_PINS-1:0] mask_q;
    logic               mode_q;

    logic wr_sense, wr_prio, wr_src, wr_mset, wr_mclr, wr_mode;
    assign wr_sense = reg_we && (sel == RS_SENSE);
    assign wr_prio  = reg_we && (sel == RS_PRIO);
    assign wr_src   = reg_we && (sel == RS_SOURCE);
    assign wr_mset  = reg_we && (sel == RS_MSET);
    assign wr_mclr  = reg_we && (sel == RS_MCLR);
    assign wr_mode  = reg_we && (sel == RS_MODE);

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_field
        localparam int SNS_LSB = field_lsb(n, SENSE_W);
        localparam int PRI_LSB = field_lsb(n, PRIO_W);
        localparam int SRC_BIT = bit_pos(n, SRC_W);

        always_ff @(posedge clk) begin
            if (rst) begin
                sense_q[n] <= '0;
                prio_q[n]  <= '0;
                mask_q[n]  <= 1'b1;
            end else begin
                if (wr_sense) sense_q[n] <= reg_wdata[SNS_LSB +: SENSE_W];
                if (wr_prio)  prio_q[n]  <= reg_wdata[PRI_LSB +: PRIO_W];
                if (wr_mset && reg_wdata[SRC_BIT])      mask_q[n] <= 1'b1;
                else if (wr_mclr && reg_wdata[SRC_BIT]) mask_q[n] <= 1'b0;
            end
        end

        assign sense_code_o[n*4 +: 4] = 4'(sense_q[n]);
        assign prio_en_o[n]           = |prio_q[n];
        assign mask_o[n]              = mask_q[n];
        assign clr_o[n]               = wr_src && !reg_wdata[SRC_BIT];

        // R7: a one written to mask-set masks the pin on the next cycle
        a_r7_mask_set: assert property (@(posedge clk) disable iff (rst)
            (wr_mset && reg_wdata[SRC_BIT]) |=> mask_q[n]);

        // R7: a one written to mask-clear unmasks the pin on the next cycle
        a_r7_mask_clr: assert property (@(posedge clk) disable iff (rst)
            (wr_mclr && reg_wdata[SRC_BIT]) |=> !mask_q[n]);

        // R7: a zero bit in either mask write keeps the mask state
        a_r7_zero_keeps: assert property (@(posedge clk) disable iff (rst)
            ((wr_mset || wr_mclr) && !reg_wdata[SRC_BIT]) |=> $stable(mask_q[n]));
    end

    always_ff @(posedge clk) begin
        if (rst)          mode_q <= 1'b0;
        else if (wr_mode) mode_q <= reg_wdata[MODE_BIT];
    end
    assign indiv_mode_o = mode_q;

    always_comb begin
        reg_rdata = '0;
        case (sel)
            RS_SENSE: begin
                for (int n = 0; n < NUM_PINS; n++)
                    reg_rdata[field_lsb(n, SENSE_W) +: SENSE_W] = sense_q[n];
            end
            RS_PRIO: begin
                for (int n = 0; n < NUM_PINS; n++)
                    reg_rdata[field_lsb(n, PRIO_W) +: PRIO_W] = prio_q[n];
            end
            RS_SOURCE: begin
                for (int n = 0; n < NUM_PINS; n++)
                    reg_rdata[bit_pos(n, SRC_W)] = pend_i[n];
            end
            RS_MODE:  reg_rdata[MODE_BIT] = mode_q;
            default:  reg_rdata = '0;
        endcase
    end

    // R7: the write-only mask registers never return data
    a_r7_wo_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (sel == RS_MSET || sel == RS_MCLR) |-> (reg_rdata == '0));

endmodule

// File: rtl/extirq_ctrl.sv
module extirq_ctrl
    import extirq_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int SENSE_W  = 4,
    parameter int SRC_W    = 8
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pins_i,
    input  logic [2:0]          reg_addr,
    input  logic                reg_we,
    input  logic [31:0]         reg_wdata,
    output logic [31:0]         reg_rdata,
    output logic [NUM_PINS-1:0] irq_o,
    output logic                irq_any_o
);

    logic [NUM_PINS-1:0]   lvl, prev, pend, prio_en, mask, clr, qual;
    logic [NUM_PINS*4-1:0] sense_code;
    logic                  indiv_mode;

    extirq_sync #(.NUM_PINS(NUM_PINS)) sync_i (
        .clk    (clk),
        .rst    (rst),
        .pins_i (pins_i),
        .lvl_o  (lvl),
        .prev_o (prev)
    );

    extirq_regs #(
        .NUM_PINS (NUM_PINS),
        .SENSE_W  (SENSE_W),
        .SRC_W    (SRC_W)
    ) regs_i (
        .clk          (clk),
        .rst          (rst),
        .reg_addr     (reg_addr),
        .reg_we       (reg_we),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .pend_i       (pend),
        .sense_code_o (sense_code),
        .prio_en_o    (prio_en),
        .mask_o       (mask),
        .clr_o        (clr),
        .indiv_mode_o (indiv_mode)
    );

    for (genvar n = 0; n < NUM_PINS; n++) begin : g_cell
        extirq_pend_cell cell_i (
            .clk    (clk),
            .rst    (rst),
            .sel_i  (decode_sense(sense_code[n*4 +: 4])),
            .lvl_i  (lvl[n]),
            .prev_i (prev[n]),
            .clr_i  (clr[n]),
            .pend_o (pend[n])
        );
        assign qual[n] = pend[n] & ~mask[n] & prio_en[n];
    end

    assign irq_any_o = |qual;
    assign irq_o     = indiv_mode ? qual : '0;

    // R9: the combined output never fires without some pending pin
    a_r9_any_needs_pend: assert property (@(posedge clk) disable iff (rst)
        irq_any_o |-> (pend != '0));

    // R9: with the mode bit clear no per-pin output is driven
    a_r9_mode_gate: assert property (@(posedge clk) disable iff (rst)
        !indiv_mode |-> (irq_o == '0));

    // R7 / R8: a masked or zero-priority pin is silent
    a_r8_gates: assert property (@(posedge clk) disable iff (rst)
        ((mask | ~prio_en) & irq_o) == '0);

endmodule

// File: tb/extirq_ctrl_tb.sv
module extirq_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  pins = '0;
    logic [2:0]  addr = '0;
    logic        we = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [7:0]  irq;
    logic        irq_any;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    extirq_ctrl dut_i (
        .clk       (clk),
        .rst       (rst),
        .pins_i    (pins),
        .reg_addr  (addr),
        .reg_we    (we),
        .reg_wdata (wdata),
        .reg_rdata (rdata),
        .irq_o     (irq),
        .irq_any_o (irq_any)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        addr = a; wdata = d; we = 1'b1;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic settle(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_pin(input int n, input logic v);
        @(negedge clk);
        pins[n] = v;
    endtask

    task automatic chk_src(input string tag, input logic [7:0] exp);
        logic [31:0] d;
        rd(3'd2, d);
        chk(tag, d, {24'h0, exp});
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(3'd0, d); chk("R1 sense after reset", d, 32'h0);
        rd(3'd1, d); chk("R1 prio after reset", d, 32'h0);
        rd(3'd2, d); chk("R1 source after reset", d, 32'h0);
        rd(3'd5, d); chk("R1 mode after reset", d, 32'h0);
        chk("R1 irq_o after reset", {24'h0, irq}, 32'h0);
        chk("R1 irq_any after reset", {31'h0, irq_any}, 32'h0);
    endtask

    task automatic t_layout();
        logic [31:0] d;
        wr(3'd0, 32'h0123_4000);
        rd(3'd0, d); chk("R2 sense readback", d, 32'h0123_4000);
        wr(3'd1, 32'h8000_000F);
        rd(3'd1, d); chk("R2 prio readback", d, 32'h8000_000F);
        wr(3'd5, 32'hFFFF_FFFF);
        rd(3'd5, d); chk("R9 mode keeps only bit 23", d, 32'h0080_0000);
        wr(3'd0, 32'h0); wr(3'd1, 32'h0); wr(3'd5, 32'h0); wr(3'd2, 32'h0);
        chk_src("R6 clear after layout", 8'h00);
    endtask

    task automatic t_rise();
        wr(3'd0, 32'h0001_0000);
        wr(3'd2, 32'h0);
        set_pin(3, 1'b1);
        settle(2); chk_src("R3 rise not yet visible after two edges", 8'h00);
        settle(1); chk_src("R3 rise pending pin3", 8'h10);
        wr(3'd2, 32'h0); chk_src("R6 clear pin3", 8'h00);
        set_pin(3, 1'b0);
        settle(3); chk_src("R3 rising mode ignores fall", 8'h00);
    endtask

    task automatic t_fall();
        wr(3'd0, 32'h0);
        wr(3'd2, 32'h0);
        set_pin(5, 1'b1);
        settle(3); chk_src("R3 falling mode ignores rise", 8'h00);
        set_pin(5, 1'b0);
        settle(3); chk_src("R3 fall pending pin5", 8'h04);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_both();
        wr(3'd0, 32'h0400_0000);
        wr(3'd2, 32'h0);
        set_pin(1, 1'b1);
        settle(3); chk_src("R4 both edges rise", 8'h40);
        wr(3'd2, 32'hBF); chk_src("R6 clear via inverted mask", 8'h00);
        set_pin(1, 1'b0);
        settle(3); chk_src("R4 both edges fall", 8'h40);
        wr(3'd2, 32'h0);
        wr(3'd0, 32'h0700_0000);
        set_pin(1, 1'b1); settle(3);
        set_pin(1, 1'b0); settle(3);
        chk_src("R4 code 7 detects nothing", 8'h00);
        wr(3'd0, 32'h0F00_0000);
        set_pin(1, 1'b1); settle(3);
        set_pin(1, 1'b0); settle(3);
        chk_src("R4 code 15 detects nothing", 8'h00);
    endtask

    task automatic t_level();
        wr(3'd0, 32'h0000_0030);
        wr(3'd2, 32'h0);
        set_pin(6, 1'b1);
        settle(3); chk_src("R5 high level pending", 8'h02);
        wr(3'd2, 32'h0); chk_src("R5 clear blocked while active", 8'h02);
        set_pin(6, 1'b0);
        settle(3); chk_src("R5 high level released", 8'h00);
        wr(3'd0, 32'h0000_0002);
        settle(1); chk_src("R5 low level pending", 8'h01);
        set_pin(7, 1'b1);
        settle(3); chk_src("R5 low level released", 8'h00);
        wr(3'd0, 32'h0);
        set_pin(7, 1'b0);
        settle(3);
        wr(3'd2, 32'h0);
    endtask

    task automatic t_clear();
        wr(3'd0, 32'h1010_0000);
        wr(3'd2, 32'h0);
        set_pin(0, 1'b1); set_pin(2, 1'b1);
        settle(3); chk_src("R6 two pins pending", 8'hA0);
        wr(3'd2, 32'hDF); chk_src("R6 zero clears only pin2", 8'h80);
        wr(3'd2, 32'hFF); chk_src("R6 ones keep pending", 8'h80);
        wr(3'd2, 32'h0);  chk_src("R6 all zeros clear all", 8'h00);
        set_pin(0, 1'b0); set_pin(2, 1'b0);
        settle(3); chk_src("R6 nothing on fall in rising mode", 8'h00);
    endtask

    task automatic t_gate();
        logic [31:0] d;
        wr(3'd0, 32'h1000_0000);
        wr(3'd2, 32'h0);
        wr(3'd1, 32'hF000_0000);
        wr(3'd5, 32'h0080_0000);
        set_pin(0, 1'b1);
        settle(3);
        chk("R1 pin masked from reset", {23'h0, irq_any, irq}, 32'h0);
        wr(3'd4, 32'h0);
        chk("R7 zero unmask write ignored", {24'h0, irq}, 32'h0);
        wr(3'd4, 32'h80);
        chk("R7 unmask pin0 irq_o", {24'h0, irq}, 32'h01);
        chk("R9 irq_any follows pin0", {31'h0, irq_any}, 32'h1);
        rd(3'd3, d); chk("R7 mask-set reads zero", d, 32'h0);
        rd(3'd4, d); chk("R7 mask-clear reads zero", d, 32'h0);
        wr(3'd3, 32'h7F);
        chk("R7 masking other pins leaves pin0", {24'h0, irq}, 32'h01);
        wr(3'd3, 32'h80);
        chk("R7 mask pin0", {23'h0, irq_any, irq}, 32'h0);
        wr(3'd4, 32'h80);
        chk("R7 unmask pin0 again", {24'h0, irq}, 32'h01);
        wr(3'd1, 32'h0);
        chk("R8 zero priority blocks", {23'h0, irq_any, irq}, 32'h0);
        wr(3'd1, 32'h1000_0000);
        chk("R8 nonzero priority allows", {24'h0, irq}, 32'h01);
        wr(3'd5, 32'h0);
        chk("R9 mode clear silences irq_o", {24'h0, irq}, 32'h0);
        chk("R9 irq_any independent of mode", {31'h0, irq_any}, 32'h1);
        wr(3'd5, 32'h0080_0000);
        chk("R9 mode set restores irq_o", {24'h0, irq}, 32'h01);
        set_pin(0, 1'b0);
        settle(3);
        wr(3'd2, 32'h0);
        chk("R6 cleared pin drops outputs", {23'h0, irq_any, irq}, 32'h0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_layout();
        t_rise();
        t_fall();
        t_both();
        t_level();
        t_clear();
        t_gate();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule